// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a small field-configurable logic device built from ordinary synthesizable logic. A bank of product terms forms wide ANDs over a literal set. The literal set holds every logic input and every macrocell feedback value, each in true and complemented form. The product terms are then ORed into output sums. The OR stage runs in one of two modes, chosen by a configuration bit. In the programmable mode each term-to-sum link is set by configuration. In the fixed mode each sum owns a dedicated, contiguous group of terms.

Each sum drives an output macrocell, which has three settings:
- It drives its pin straight from the sum.
- It drives its pin from a flip-flop that samples the sum on the clock.
- It releases the pin, so that the pin value enters the array as an input.

The macrocell value always returns to the array as a feedback literal, which allows logic of more than one level. The array is evaluated in a fixed number of unrolled passes, so no combinational loop exists in the circuit. A chain of combinational macrocells up to `FB_DEPTH + 1` levels deep settles correctly.

The whole configuration is one long shift register, loaded one bit per clock while a load strobe is high.

Top module: `sop_logic_array`

## Requirements
- R1: A product term is the AND of every literal whose connection bit is set. Literal index 2v is variable v in true form and 2v+1 is variable v complemented. Variables 0..N_IN-1 are `logic_in` bits and variable N_IN+o is the feedback of macrocell o.
- R2: In programmable OR mode (mode bit 0), output sum o is the OR of every term p whose link bit (o,p) is set.
- R3: A product term with no connected literal evaluates to 0, so an unused term never raises a sum.
- R4: In fixed OR mode (mode bit 1), sum o is the OR of terms o*G .. o*G+G-1, with G = N_PT/N_OUT. All OR link bits are ignored in this mode.
- R5: A macrocell with enable 1 and select 0 asserts `pin_oe` and drives `pin_out` with its sum in the same cycle.
- R6: A macrocell with enable 1 and select 1 drives `pin_out` from a flip-flop that samples the sum on the rising clock edge. Its output changes only at that edge.
- R7: A macrocell with enable 0 holds `pin_oe` and `pin_out` at 0, and its feedback literal takes the value of its `pin_in` bit.
- R8: The feedback of an enabled macrocell is its driven value. A combinational chain of up to FB_DEPTH+1 macrocell levels settles correctly, for example f = x1'g + x1g' with g from another macrocell.
- R9: While `cfg_load` is high, each clock shifts `cfg_din` into bit 0 of the configuration and moves every bit up by one. During this time all `pin_oe` bits are 0 and all macrocell flip-flops are held at 0. The layout is as follows. Bit 0 is the OR mode. Bit 1+o is the enable of macrocell o and bit 1+N_OUT+o is its select. Bit 1+2*N_OUT+o*N_PT+p is the OR link (o,p). Then, from base 1+2*N_OUT+N_OUT*N_PT, bit p*2*(N_IN+N_OUT)+l is the connection of term p to literal l.
- R10: Active-low reset clears the configuration and the flip-flops, so all pins come out of reset released with `pin_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration shift and macrocell flip-flops |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | High while configuration bits are shifted in |
| cfg_din | input | 1 | Serial configuration bit |
| logic_in | input | N_IN | Dedicated logic inputs |
| pin_in | input | N_OUT | Value seen on each macrocell pin |
| pin_out | output | N_OUT | Value driven on each macrocell pin |
| pin_oe | output | N_OUT | Drive enable of each macrocell pin |

## Verification
The bench first applies the two-output example pair over all eight combinations of x1..x3, with the unused inputs held random. This separates polarity errors from wrong AND/OR links. Random inputs and random pin values then run with a mixed configuration: combinational outputs, an empty term, a registered output, a released pin feeding another output, and a two-level XOR built through feedback. This shows whether the registered output lags by exactly one edge and whether the feedback chain settles. A second configuration sets every OR link but selects fixed mode, which tells group wiring apart from link decoding. Load-time blanking and flip-flop clearing are checked at the edges of a reload, and reset clearing is checked after a reset in mid-run.

// File: rtl/sop_pkg.sv
// Package: shared types and helpers for the sum-of-products logic array.
// Assumes literal pairs are packed as (true, complement) per variable.
package sop_pkg;

    // Per-macrocell configuration pair.
    typedef struct packed {
        logic en;
        logic sel;
    } mc_cfg_t;

    // Index of a literal in the packed literal vector.
    function automatic int lit_index(input int var_idx, input bit inverted);
        return 2 * var_idx + (inverted ? 1 : 0);
    endfunction

endpackage

// File: rtl/sop_cfg_chain.sv
// Module: serial configuration store. Shifts one bit per clock while load
// is high; holds otherwise. Assumes synchronous active-low reset.
module sop_cfg_chain #(
    parameter int CFG_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             din,
    output logic [CFG_W-1:0] cfg_q
);

    // Shift new bit into position 0 while loading; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= {cfg_q[CFG_W-2:0], din};
        end
    end

endmodule

// File: rtl/sop_plane.sv
// Module: one evaluation of the AND plane and OR plane. Builds true and
// complemented literals from the variable vector, forms product terms,
// and ORs them into sums using either programmable links or fixed groups.
// Assumes N_PT is a multiple of N_OUT.
module sop_plane
    import sop_pkg::*;
#(
    parameter int N_VAR = 24,
    parameter int N_PT  = 32,
    parameter int N_OUT = 8
) (
    input  logic [N_VAR-1:0]         vars,
    input  logic [N_PT*2*N_VAR-1:0]  and_cfg,
    input  logic [N_OUT*N_PT-1:0]    or_cfg,
    input  logic                     or_fixed,
    output logic [N_OUT-1:0]         sums
);

    localparam int N_LIT = 2 * N_VAR;
    localparam int GRP   = N_PT / N_OUT;

    logic [N_LIT-1:0] lits;
    logic [N_PT-1:0]  terms;

    // Expand each variable into its true and complemented literal.
    always_comb begin
        for (int v = 0; v < N_VAR; v++) begin
            lits[lit_index(v, 1'b0)] = vars[v];
            lits[lit_index(v, 1'b1)] = ~vars[v];
        end
    end

    // One wide AND per product term; an empty term yields 0.
    for (genvar p = 0; p < N_PT; p++) begin : g_term
        logic [N_LIT-1:0] conn;
        assign conn     = and_cfg[p*N_LIT +: N_LIT];
        assign terms[p] = (|conn) & (&(lits | ~conn));
    end

    // One OR per output over the linked or grouped terms.
    for (genvar o = 0; o < N_OUT; o++) begin : g_sum
        logic [N_PT-1:0] link;
        for (genvar p = 0; p < N_PT; p++) begin : g_link
            localparam bit IN_GROUP = ((p / GRP) == o);
            assign link[p] = or_fixed ? IN_GROUP : or_cfg[o*N_PT + p];
        end
        assign sums[o] = |(terms & link);
    end

endmodule

// File: rtl/sop_macrocell.sv
// Module: output macrocell. Selects combinational or registered sum,
// enables or releases the pin, and provides the non-combinational part
// of the feedback literal. Assumes hold_clr is high during config load.
module sop_macrocell (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    input  logic en,
    input  logic sel,
    input  logic sum_in,
    input  logic pad_in,
    output logic q_o,
    output logic pin_o,
    output logic oe_o,
    output logic fb_static_o,
    output logic is_comb_o
);

    logic en_eff;

    // Pin drive is suppressed while configuration is loading.
    assign en_eff = en & ~hold_clr;

    // Sample the final sum each clock; cleared by reset and during load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (hold_clr) begin
            q_o <= 1'b0;
        end else begin
            q_o <= sum_in;
        end
    end

    // Drive pin and form the static feedback source.
    always_comb begin
        oe_o        = en_eff;
        is_comb_o   = en_eff & ~sel;
        pin_o       = en_eff ? (sel ? q_o : sum_in) : 1'b0;
        fb_static_o = en_eff ? q_o : pad_in;
    end

endmodule

// File: rtl/sop_logic_array.sv
// Module: top of the configurable sum-of-products device. Decodes the
// serial configuration, evaluates the array in FB_DEPTH+1 unrolled passes
// so combinational feedback settles without a circuit loop, and drives the
// output macrocells. Assumes combinational feedback chains are acyclic and
// at most FB_DEPTH+1 levels deep.
module sop_logic_array
    import sop_pkg::*;
#(
    parameter int N_IN     = 16,
    parameter int N_PT     = 32,
    parameter int N_OUT    = 8,
    parameter int FB_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic              cfg_din,
    input  logic [N_IN-1:0]   logic_in,
    input  logic [N_OUT-1:0]  pin_in,
    output logic [N_OUT-1:0]  pin_out,
    output logic [N_OUT-1:0]  pin_oe
);

    localparam int N_VAR    = N_IN + N_OUT;
    localparam int N_LIT    = 2 * N_VAR;
    localparam int OR_BASE  = 1 + 2 * N_OUT;
    localparam int AND_BASE = OR_BASE + N_OUT * N_PT;
    localparam int CFG_W    = AND_BASE + N_PT * N_LIT;

    logic [CFG_W-1:0]        cfg_q;
    logic                    or_fixed;
    mc_cfg_t [N_OUT-1:0]     mc_cfg;
    logic [N_OUT-1:0]        mc_sel;
    logic [N_OUT*N_PT-1:0]   or_cfg;
    logic [N_PT*N_LIT-1:0]   and_cfg;
    logic [N_OUT-1:0]        sum_final;
    logic [N_OUT-1:0]        reg_q;
    logic [N_OUT-1:0]        fb_static;
    logic [N_OUT-1:0]        is_comb;

    sop_cfg_chain #(.CFG_W(CFG_W)) cfg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .din   (cfg_din),
        .cfg_q (cfg_q)
    );

    // Split the configuration image into its fields.
    always_comb begin
        or_fixed = cfg_q[0];
        for (int o = 0; o < N_OUT; o++) begin
            mc_cfg[o].en  = cfg_q[1 + o];
            mc_cfg[o].sel = cfg_q[1 + N_OUT + o];
            mc_sel[o]     = mc_cfg[o].sel;
        end
        or_cfg  = cfg_q[AND_BASE-1:OR_BASE];
        and_cfg = cfg_q[CFG_W-1:AND_BASE];
    end

    // Unrolled evaluation passes; pass k sees the sums of pass k-1.
    for (genvar k = 0; k <= FB_DEPTH; k++) begin : g_pass
        logic [N_VAR-1:0] vars;
        logic [N_OUT-1:0] sums;
        if (k == 0) begin : g_first
            assign vars = {fb_static & ~is_comb, logic_in};
        end else begin : g_next
            assign vars = {(fb_static & ~is_comb) | (g_pass[k-1].sums & is_comb),
                           logic_in};
        end
        sop_plane #(.N_VAR(N_VAR), .N_PT(N_PT), .N_OUT(N_OUT)) plane_i (
            .vars     (vars),
            .and_cfg  (and_cfg),
            .or_cfg   (or_cfg),
            .or_fixed (or_fixed),
            .sums     (sums)
        );
    end

    assign sum_final = g_pass[FB_DEPTH].sums;

    // One macrocell per output.
    for (genvar o = 0; o < N_OUT; o++) begin : g_mc
        sop_macrocell mc_i (
            .clk         (clk),
            .rst_n       (rst_n),
            .hold_clr    (cfg_load),
            .en          (mc_cfg[o].en),
            .sel         (mc_cfg[o].sel),
            .sum_in      (sum_final[o]),
            .pad_in      (pin_in[o]),
            .q_o         (reg_q[o]),
            .pin_o       (pin_out[o]),
            .oe_o        (pin_oe[o]),
            .fb_static_o (fb_static[o]),
            .is_comb_o   (is_comb[o])
        );
    end

endmodule

// File: rtl/sop_logic_array_chk.sv
// Module: assertion checker for the sum-of-products array, bound to the top.
// Assumes synchronous active-low reset on rst_n.
module sop_logic_array_chk #(
    parameter int N_OUT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_load,
    input logic [N_OUT-1:0] pin_in,
    input logic [N_OUT-1:0] pin_out,
    input logic [N_OUT-1:0] pin_oe,
    input logic [N_OUT-1:0] mc_sel,
    input logic [N_OUT-1:0] sum_final,
    input logic [N_OUT-1:0] reg_q,
    input logic [N_OUT-1:0] fb_static
);

    // R9: loading blanks every pin.
    a_r9_load_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> (pin_oe == '0));

    // R9: flip-flops are held clear after a load cycle.
    a_r9_flops_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> (reg_q == '0));

    // R5: combinational macrocells pass the array sum to the pin.
    a_r5_comb_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & ~mc_sel) & (pin_out ^ sum_final)) == '0);

    // R6: registered macrocells show the sum sampled one edge earlier.
    a_r6_reg_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load) |=> (cfg_load ||
            ((pin_oe & mc_sel & $past(pin_oe & mc_sel) &
              (pin_out ^ $past(sum_final))) == '0)));

    // R7: released pins drive nothing and feed their pin value back.
    a_r7_released_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((~pin_oe & pin_out) == '0) && ((~pin_oe & (fb_static ^ pin_in)) == '0));

endmodule

bind sop_logic_array sop_logic_array_chk #(.N_OUT(N_OUT)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .mc_sel    (mc_sel),
    .sum_final (sum_final),
    .reg_q     (reg_q),
    .fb_static (fb_static)
);

// File: tb/sop_logic_array_tb_top.sv
`timescale 1ns/1ps
// Bench: configures the array serially and compares pins against
// expected values computed from the requirements.
module sop_logic_array_tb_top;

    localparam int N_IN     = 16;
    localparam int N_PT     = 32;
    localparam int N_OUT    = 8;
    localparam int N_LIT    = 2 * (N_IN + N_OUT);
    localparam int OR_BASE  = 1 + 2 * N_OUT;
    localparam int AND_BASE = OR_BASE + N_OUT * N_PT;
    localparam int CFG_W    = AND_BASE + N_PT * N_LIT;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_load = 1'b0;
    logic              cfg_din = 1'b0;
    logic [N_IN-1:0]   logic_in = '0;
    logic [N_OUT-1:0]  pin_in = '0;
    logic [N_OUT-1:0]  pin_out;
    logic [N_OUT-1:0]  pin_oe;

    logic [CFG_W-1:0]  img;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sop_logic_array #(.N_IN(N_IN), .N_PT(N_PT), .N_OUT(N_OUT), .FB_DEPTH(2)) dut_i (
        .clk (clk), .rst_n (rst_n), .cfg_load (cfg_load), .cfg_din (cfg_din),
        .logic_in (logic_in), .pin_in (pin_in), .pin_out (pin_out), .pin_oe (pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_and(input int p, input int l);
        img[AND_BASE + p*N_LIT + l] = 1'b1;
    endtask

    task automatic set_or(input int o, input int p);
        img[OR_BASE + o*N_PT + p] = 1'b1;
    endtask

    task automatic set_mc(input int o, input bit en, input bit sel);
        img[1 + o] = en;
        img[1 + N_OUT + o] = sel;
    endtask

    // Shift the image MSB first; checks blanking half way through (R9).
    task automatic load_cfg();
        for (int i = CFG_W - 1; i >= 0; i--) begin
            @(negedge clk);
            cfg_load = 1'b1;
            cfg_din  = img[i];
            if (i == CFG_W / 2) begin
                #1 check("R9 oe during load", 32'(pin_oe), 32'h0);
            end
        end
        @(negedge clk);
        cfg_load = 1'b0;
        cfg_din  = 1'b0;
    endtask

    function automatic logic f1(input logic [N_IN-1:0] x);
        return (x[0] & x[1]) | (x[0] & ~x[2]) | (~x[0] & ~x[1] & x[2]);
    endfunction

    function automatic logic f2(input logic [N_IN-1:0] x);
        return (x[0] & x[1]) | (~x[0] & ~x[1] & x[2]) | (x[0] & x[2]);
    endfunction

    function automatic logic fxor(input logic [N_IN-1:0] x);
        logic g;
        g = ~(x[1] ^ x[2]);
        return (~x[0] & g) | (x[0] & ~g);
    endfunction

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                total++;
                bad++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic held;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1 check("R10 oe after reset", 32'(pin_oe), 32'h0);
        check("R10 out after reset", 32'(pin_out), 32'h0);

        // Configuration A: mixed macrocell modes, programmable OR.
        img = '0;
        set_and(0, 0); set_and(0, 2);                  // x1 x2
        set_and(1, 0); set_and(1, 5);                  // x1 x3'
        set_and(2, 1); set_and(2, 3); set_and(2, 4);   // x1' x2' x3
        set_and(3, 0); set_and(3, 4);                  // x1 x3
        set_or(0, 0); set_or(0, 1); set_or(0, 2);
        set_or(1, 0); set_or(1, 2); set_or(1, 3);
        set_or(2, 10);                                 // empty term
        set_and(4, 0); set_or(3, 4);                   // registered x1
        set_and(5, 2*(N_IN+4)); set_or(5, 5);          // pin 4 fed back
        set_and(6, 2); set_and(6, 4);                  // g = x2x3 + x2'x3'
        set_and(7, 3); set_and(7, 5);
        set_or(6, 6); set_or(6, 7);
        set_and(8, 1); set_and(8, 2*(N_IN+6));         // x1' g
        set_and(9, 0); set_and(9, 2*(N_IN+6)+1);       // x1 g'
        set_or(7, 8); set_or(7, 9);
        for (int o = 0; o < N_OUT; o++) set_mc(o, 1'b1, 1'b0);
        set_mc(3, 1'b1, 1'b1);
        set_mc(4, 1'b0, 1'b0);

        logic_in = 16'h0001;
        load_cfg();
        #1 check("R9 flop cleared by load", 32'(pin_out[3]), 32'h0);
        check("R7 oe map", 32'(pin_oe), 32'hEF);
        @(posedge clk);
        #1 check("R6 capture at edge", 32'(pin_out[3]), 32'h1);
        held = 1'b1;

        // Example pair over all input combos (R1, R2, R5).
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            logic_in = {13'(($urandom) & 16'h1fff), 3'(c)};
            #1 check("R1 f1", 32'(pin_out[0]), 32'(f1(logic_in)));
            check("R2 f2", 32'(pin_out[1]), 32'(f2(logic_in)));
            check("R5 oe comb", 32'(pin_oe[1:0]), 32'h3);
            check("R6 reg lags", 32'(pin_out[3]), 32'(held));
            @(posedge clk);
            held = logic_in[0];
        end

        // Random inputs and pins.
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            logic_in = 16'($urandom);
            pin_in   = 8'($urandom);
            #1 check("R1 f1 rand", 32'(pin_out[0]), 32'(f1(logic_in)));
            check("R2 f2 rand", 32'(pin_out[1]), 32'(f2(logic_in)));
            check("R3 empty term", 32'(pin_out[2]), 32'h0);
            check("R6 reg lags rand", 32'(pin_out[3]), 32'(held));
            check("R7 released pin", 32'({pin_oe[4], pin_out[4]}), 32'h0);
            check("R7 pin feedback", 32'(pin_out[5]), 32'(pin_in[4]));
            check("R8 two-level", 32'(pin_out[7]), 32'(fxor(logic_in)));
            @(posedge clk);
            held = logic_in[0];
        end

        // Configuration B: fixed OR mode with every link set (R4).
        img = '0;
        img[0] = 1'b1;
        for (int o = 0; o < N_OUT; o++) begin
            set_mc(o, 1'b1, 1'b0);
            for (int p = 0; p < N_PT; p++) set_or(o, p);
        end
        set_and(0, 0);    // group of output 0
        set_and(5, 2);    // group of output 1
        set_and(8, 4);    // group of output 2
        load_cfg();
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            logic_in = {13'h0, 3'(c)};
            #1 check("R4 fixed groups", 32'(pin_out), 32'({5'b0, 3'(c)}));
        end

        // Reset in mid-run clears configuration (R10).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1 check("R10 oe after mid reset", 32'(pin_oe), 32'h0);
        check("R10 out after mid reset", 32'(pin_out), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule